// File: doc/BRIEF.md
# Outbound Address Translation Window Bank

This block turns local host addresses into bus addresses for an outbound bridge path. It holds a small bank of programmable windows. Each window has a 4 KiB-aligned local base, a power-of-two size, a translated bus base and a pair of transaction-type codes, one for reads and one for writes. Each lookup request presents a local address and a read/write flag. One clock later the block returns the winning window, the translated bus address and the transaction type, or it reports a miss.

Window 0 is the catch-all. When it is enabled it takes every address that no other window claims. It does not compare against a base of its own. Windows 1 and up are range windows and are checked in ascending order. Software programs the windows through a simple 32-bit register read/write port, with four registers per window.

Top module: `obwin_xlate`

## Requirements
- R1: After reset, every window's attribute register reads 0x0004401F, every translation, extended-translation and base register reads 0, and rsp_valid is 0.
- R2: Window n (n = 0..4) decodes at reg_addr 0xC00+0x20n. Sub-offset 0x00 is translation, 0x04 is extended translation, 0x08 is local base and 0x10 is attributes. A read returns data on reg_rdata one cycle after reg_re. Any other offset reads 0, and a write to it changes no register.
- R3: A window takes part in lookups only when attribute bit 31 is 1 and the size code in attribute bits 4:0 is 11 or more. Otherwise it never claims an address.
- R4: A usable window n (n >= 1) has size 2^(code+1). It claims an address whose bits above log2(size) equal those of (base << 12).
- R5: When several of windows 1..4 claim an address, the lowest-numbered one wins.
- R6: Window 0, if usable, claims any address that no window 1..4 claims. If no window claims the address, the response has rsp_hit=0, rsp_win=0, rsp_bus_addr=0, rsp_ttype=0 and rsp_io=0.
- R7: On a hit the 48-bit bus address is ({ext[3:0], trans[31:0]} << 12) | (address & (size-1)), using the winning window's registers.
- R8: A read takes its type from attribute bits 19:16 and a write from bits 15:12. Code 0x4 means memory and 0x8 means I/O. rsp_ttype carries the code, and rsp_io is 1 exactly when the code is 0x8.
- R9: The response is registered. rsp_valid is 1 exactly one cycle after req_valid. A register write in the same cycle as a lookup does not affect that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_re |
| req_valid | input | 1 | Lookup request valid |
| req_write | input | 1 | Lookup is a write (1) or a read (0) |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Some window claimed the address |
| rsp_win | output | 3 | Winning window number |
| rsp_bus_addr | output | 48 | Translated bus address |
| rsp_ttype | output | 4 | Transaction-type code |
| rsp_io | output | 1 | Transaction is I/O space |

## Verification
The hardest situation to reach from the ports is several usable windows claiming the same address, combined with the fallback to window 0. The stimulus sets this up on purpose. One window sits completely inside another, so both claim part of the address space. A further window is enabled but has an undersized size code. Window 0 is switched on only after a miss has been observed. A register write is also issued in the same cycle as a lookup, to show that the response is built from the configuration as it stood before the write.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int REG_W    = 32;
  localparam int PAGE_SH  = 12;
  localparam int OFF_W    = 12;
  localparam int CODE_MIN = 11;
  localparam logic [REG_W-1:0] ATTR_RST = 32'h0004_401F;
  localparam logic [3:0] TT_IO = 4'h8;

  typedef struct packed {
    logic [REG_W-1:0] trans;
    logic [REG_W-1:0] ext;
    logic [REG_W-1:0] base;
    logic [REG_W-1:0] attr;
  } win_cfg_t;

  typedef enum logic [1:0] {SUB_TRANS, SUB_EXT, SUB_BASE, SUB_ATTR} sub_e;

  function automatic logic win_usable(input logic [REG_W-1:0] attr);
    return attr[31] && (attr[4:0] >= 5'(CODE_MIN));
  endfunction
endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
  import obwin_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic                    reg_re,
  input  logic [OFF_W-1:0]        reg_addr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  output win_cfg_t [NUM_WIN-1:0]  cfg
);
  logic       dec_ok;
  logic [2:0] dec_win;
  sub_e       dec_sub;
  logic [REG_W-1:0] rd_mux;
  win_cfg_t [NUM_WIN-1:0] cfg_q;

  // Windows are strided by 0x20 inside the 0xC00 page.
  always_comb begin
    dec_ok  = 1'b0;
    dec_sub = SUB_TRANS;
    dec_win = reg_addr[7:5];
    if (reg_addr[11:8] == 4'hC && {1'b0, reg_addr[7:5]} < 4'(NUM_WIN)) begin
      case (reg_addr[4:0])
        5'h00: begin dec_ok = 1'b1; dec_sub = SUB_TRANS; end
        5'h04: begin dec_ok = 1'b1; dec_sub = SUB_EXT;   end
        5'h08: begin dec_ok = 1'b1; dec_sub = SUB_BASE;  end
        5'h10: begin dec_ok = 1'b1; dec_sub = SUB_ATTR;  end
        default: dec_ok = 1'b0;
      endcase
    end
  end

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[n].trans <= '0;
        cfg_q[n].ext   <= '0;
        cfg_q[n].base  <= '0;
        cfg_q[n].attr  <= ATTR_RST;
      end else if (reg_we && dec_ok && dec_win == 3'(n)) begin
        case (dec_sub)
          SUB_TRANS: cfg_q[n].trans <= reg_wdata;
          SUB_EXT:   cfg_q[n].ext   <= reg_wdata;
          SUB_BASE:  cfg_q[n].base  <= reg_wdata;
          default:   cfg_q[n].attr  <= reg_wdata;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NUM_WIN; n++) begin
      if (dec_ok && dec_win == 3'(n)) begin
        case (dec_sub)
          SUB_TRANS: rd_mux = cfg_q[n].trans;
          SUB_EXT:   rd_mux = cfg_q[n].ext;
          SUB_BASE:  rd_mux = cfg_q[n].base;
          default:   rd_mux = cfg_q[n].attr;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  assign cfg = cfg_q;

  // R2: configuration only moves on a write strobe
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !reg_we |=> $stable(cfg_q));
endmodule

// File: rtl/obwin_match.sv
module obwin_match
  import obwin_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int ADDR_W  = 32,
  parameter int BUS_AW  = 48
) (
  input  win_cfg_t [NUM_WIN-1:0]          cfg,
  input  logic [ADDR_W-1:0]               lk_addr,
  output logic [NUM_WIN-1:0]              hit,
  output logic [NUM_WIN-1:0][BUS_AW-1:0]  mask
);
  localparam int BASE_W = ADDR_W - PAGE_SH;

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_cmp
    logic [ADDR_W-1:0] base_addr;
    logic              usable;

    always_comb begin
      for (int i = 0; i < BUS_AW; i++)
        mask[n][i] = (i <= int'(cfg[n].attr[4:0]));
    end

    assign usable    = win_usable(cfg[n].attr);
    assign base_addr = {cfg[n].base[BASE_W-1:0], {PAGE_SH{1'b0}}};

    if (n == 0) begin : g_default
      assign hit[n] = usable;
    end else begin : g_range
      assign hit[n] = usable &&
        (((lk_addr ^ base_addr) & ~mask[n][ADDR_W-1:0]) == '0);
    end
  end
endmodule

// File: rtl/obwin_select.sv
module obwin_select
  import obwin_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int ADDR_W  = 32,
  parameter int BUS_AW  = 48,
  parameter int WIN_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  win_cfg_t [NUM_WIN-1:0]          cfg,
  input  logic [NUM_WIN-1:0]              hit,
  input  logic [NUM_WIN-1:0][BUS_AW-1:0]  mask,
  output logic                            rsp_valid,
  output logic                            rsp_hit,
  output logic [WIN_W-1:0]                rsp_win,
  output logic [BUS_AW-1:0]               rsp_bus_addr,
  output logic [3:0]                      rsp_ttype,
  output logic                            rsp_io
);
  localparam int WIDE_W = 2 * REG_W + PAGE_SH;

  logic                 found;
  logic [WIN_W-1:0]     sel;
  logic [NUM_WIN-1:0]   grant;
  win_cfg_t             pick;
  logic [BUS_AW-1:0]    pick_mask;
  logic [WIDE_W-1:0]    wide;
  logic [BUS_AW-1:0]    bus_addr;
  logic [3:0]           ttype;

  // Range windows first in ascending order; window 0 only as fallback.
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int n = 1; n < NUM_WIN; n++) begin
      if (hit[n] && !found) begin
        found = 1'b1;
        sel   = WIN_W'(n);
      end
    end
    if (!found && hit[0]) found = 1'b1;
    grant = '0;
    for (int n = 0; n < NUM_WIN; n++)
      grant[n] = found && (sel == WIN_W'(n));
  end

  always_comb begin
    pick      = '0;
    pick_mask = '0;
    for (int n = 0; n < NUM_WIN; n++) begin
      if (grant[n]) begin
        pick      = cfg[n];
        pick_mask = mask[n];
      end
    end
    wide     = {pick.ext, pick.trans, {PAGE_SH{1'b0}}};
    bus_addr = wide[BUS_AW-1:0] | (BUS_AW'(req_addr) & pick_mask);
    ttype    = req_write ? pick.attr[15:12] : pick.attr[19:16];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_win      <= '0;
      rsp_bus_addr <= '0;
      rsp_ttype    <= '0;
      rsp_io       <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit      <= found;
        rsp_win      <= found ? sel : '0;
        rsp_bus_addr <= found ? bus_addr : '0;
        rsp_ttype    <= found ? ttype : '0;
        rsp_io       <= found && (ttype == TT_IO);
      end
    end
  end

  // R5: the grant goes to at most one window and only to one that claimed
  assert_grant_legal_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~hit) == '0));

  // R4: any claim from the comparators becomes a hit in the response
  assert_claim_gives_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (|hit)) |=> rsp_hit);

  // R9: one response per request, one cycle later
  assert_rsp_latency_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R6: a miss carries no address or type
  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_bus_addr == '0 && rsp_ttype == '0 && !rsp_io));
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obwin_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int ADDR_W  = 32,
  parameter int BUS_AW  = 48,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [11:0]        reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [WIN_W-1:0]   rsp_win,
  output logic [BUS_AW-1:0]  rsp_bus_addr,
  output logic [3:0]         rsp_ttype,
  output logic               rsp_io
);
  win_cfg_t [NUM_WIN-1:0]          cfg;
  logic [NUM_WIN-1:0]              hit;
  logic [NUM_WIN-1:0][BUS_AW-1:0]  mask;

  obwin_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg(cfg)
  );

  obwin_match #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .BUS_AW(BUS_AW)) u_match (
    .cfg(cfg), .lk_addr(req_addr), .hit(hit), .mask(mask)
  );

  obwin_select #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .BUS_AW(BUS_AW),
                 .WIN_W(WIN_W)) u_sel (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .cfg(cfg), .hit(hit), .mask(mask),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_bus_addr(rsp_bus_addr), .rsp_ttype(rsp_ttype), .rsp_io(rsp_io)
  );
endmodule

// File: tb/obwin_xlate_tb.sv
module obwin_xlate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {addr[32], write, hit, win[3], bus[48], ttype[4]}
  localparam logic [88:0] VEC [NV] = '{
    {32'h1000_0000, 1'b0, 1'b1, 3'd1, 48'h0000_8000_0000, 4'h4},
    {32'h1ABC_DEF0, 1'b0, 1'b1, 3'd1, 48'h0000_8ABC_DEF0, 4'h4},
    {32'h1FFF_FFFF, 1'b1, 1'b1, 3'd1, 48'h0000_8FFF_FFFF, 4'h4},
    {32'h2000_0010, 1'b0, 1'b1, 3'd2, 48'h3000_0001_0010, 4'h8},
    {32'h20FF_FFFF, 1'b1, 1'b1, 3'd2, 48'h3000_00FF_FFFF, 4'h8},
    {32'h2100_0000, 1'b0, 1'b1, 3'd3, 48'h0000_A100_0000, 4'h4},
    {32'h2100_0000, 1'b1, 1'b1, 3'd3, 48'h0000_A100_0000, 4'h8},
    {32'h3000_0000, 1'b0, 1'b1, 3'd0, 48'h0000_00F0_0000, 4'h4},
    {32'h4001_2345, 1'b1, 1'b1, 3'd0, 48'h0000_00F1_2345, 4'h4},
    {32'h0FFF_FFFF, 1'b0, 1'b1, 3'd0, 48'h0000_00FF_FFFF, 4'h4},
    {32'h3000_0FFF, 1'b0, 1'b1, 3'd0, 48'h0000_00F0_0FFF, 4'h4}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic rsp_valid, rsp_hit, rsp_io;
  logic [2:0] rsp_win;
  logic [47:0] rsp_bus_addr;
  logic [3:0] rsp_ttype;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  obwin_xlate u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_win(rsp_win),
    .rsp_bus_addr(rsp_bus_addr), .rsp_ttype(rsp_ttype), .rsp_io(rsp_io)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(posedge clk); #1; reg_re = 1'b0;
    checks++;
    if (reg_rdata !== exp) begin
      failures++;
      $display("FAIL %s: reg 0x%03h actual 0x%08h expected 0x%08h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic check_rsp(input logic hit, input logic [2:0] win,
                           input logic [47:0] bus, input logic [3:0] tt, input string tag);
    logic io;
    io = hit && (tt == 4'h8);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== hit || rsp_win !== win ||
        rsp_bus_addr !== bus || rsp_ttype !== tt || rsp_io !== io) begin
      failures++;
      $display("FAIL %s: actual v=%b hit=%b win=%0d bus=0x%012h tt=%h io=%b expected v=1 hit=%b win=%0d bus=0x%012h tt=%h io=%b",
               tag, rsp_valid, rsp_hit, rsp_win, rsp_bus_addr, rsp_ttype, rsp_io,
               hit, win, bus, tt, io);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic w, input logic hit,
                      input logic [2:0] win, input logic [47:0] bus,
                      input logic [3:0] tt, input string tag);
    @(negedge clk); req_valid = 1'b1; req_write = w; req_addr = a;
    @(posedge clk); #1; req_valid = 1'b0;
    check_rsp(hit, win, bus, tt, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    checks++;
    if (rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1: rsp_valid actual %b expected 0", rsp_valid);
    end
    for (int n = 0; n < 5; n++) rd(12'(12'hC10 + 32 * n), 32'h0004_401F, "R1 attr");
    rd(12'hC00, 32'h0, "R1 trans");
    rd(12'hC44, 32'h0, "R1 ext");
    rd(12'hC88, 32'h0, "R1 base");

    // R6: nothing usable -> miss
    look(32'h1000_0000, 1'b0, 1'b0, 3'd0, 48'h0, 4'h0, "R6 miss after reset");

    // configuration
    wr(12'hC20, 32'h0008_0000); wr(12'hC28, 32'h0001_0000); wr(12'hC30, 32'h8004_401B);
    wr(12'hC40, 32'h0000_0010); wr(12'hC44, 32'h0000_0003);
    wr(12'hC48, 32'h0002_0000); wr(12'hC50, 32'h8008_8017);
    wr(12'hC60, 32'h000A_0000); wr(12'hC68, 32'h0002_0000); wr(12'hC70, 32'h8004_801B);
    wr(12'hC80, 32'h0005_5000); wr(12'hC88, 32'h0003_0000); wr(12'hC90, 32'h8004_400A);
    wr(12'hC00, 32'h0000_0F00);

    // R2: readback of programmed registers
    rd(12'hC70, 32'h8004_801B, "R2 attr readback");
    rd(12'hC44, 32'h0000_0003, "R2 ext readback");

    // R6: window 0 still disabled -> unclaimed address misses
    look(32'h4001_2345, 1'b1, 1'b0, 3'd0, 48'h0, 4'h0, "R6 miss window0 off");

    wr(12'hC10, 32'h8004_4013);

    // R4 R5 R7 R8 R3 R6: vector table
    for (int i = 0; i < NV; i++) begin
      logic [88:0] v;
      v = VEC[i];
      look(v[88:57], v[56], v[55], v[54:52], v[51:4], v[3:0], "R4/R5/R7/R8 vector");
    end

    // R2: unmapped offsets read 0 and do not disturb windows
    wr(12'hC0C, 32'hDEAD_BEEF);
    rd(12'hC0C, 32'h0, "R2 hole sub-offset");
    wr(12'hCA0, 32'h1234_5678);
    rd(12'hCA0, 32'h0, "R2 window index 5");
    wr(12'hB20, 32'hFFFF_FFFF);
    rd(12'hB20, 32'h0, "R2 outside page");
    rd(12'hC00, 32'h0000_0F00, "R2 window0 trans intact");
    rd(12'hC20, 32'h0008_0000, "R2 window1 trans intact");

    // R3: enable bit cleared with a valid code -> falls to window 0
    wr(12'hC30, 32'h0004_401B);
    look(32'h1000_0000, 1'b0, 1'b1, 3'd0, 48'h0000_00F0_0000, 4'h4, "R3 enable clear");

    // R9: write in the same cycle as a lookup uses the old value
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 12'hC60; reg_wdata = 32'h000B_0000;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h2100_0000;
    @(posedge clk); #1; reg_we = 1'b0; req_valid = 1'b0;
    check_rsp(1'b1, 3'd3, 48'h0000_A100_0000, 4'h4, "R9 same-cycle write");
    @(posedge clk); #1;
    checks++;
    if (rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R9: idle rsp_valid actual %b expected 0", rsp_valid);
    end
    look(32'h2100_0000, 1'b0, 1'b1, 3'd3, 48'h0000_B100_0000, 4'h4, "R9 new value seen");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule